// File: doc/BRIEF.md
# Macroblock Coefficient Input Unpacker

This block sits between the receive FIFO of a 32-bit on-chip bus and a transform/quantize accelerator. For every macroblock it reads a short header from the FIFO, then a stream of packed coefficient words. The header holds three words. The first is the destination for quantized results. The second is the destination for inverse-transform results, and a dummy value may be sent there when that output is unused. The third is a control word that carries the quantizer parameter and the intra/inter choice.

After the header, the block reads 192 data words, which carry six 8x8 blocks. Each data word holds two coefficients. The block sends them to the accelerator one at a time through a 9-bit data port and a write strobe, and it paces its writes by the accelerator's column-ready signal. Words that the FIFO marks as address-valid are read and dropped.

When the last coefficient of a macroblock has been written, the block returns to header parsing. If the optional release mode is enabled, it also tells the requester that it can accept the next macroblock.

Top module: `mbu_unpacker`

## Requirements
- R1: While reset is held, and in the first cycle after it, `fifo_re_o`, `acc_wr_o`, `acc_load_qp_o` and `mb_ready_o` are 0, and `acc_qp_o` and `acc_intra_o` are 0.
- R2: `fifo_re_o` is high only in cycles where `fifo_empty_i` is low. The FIFO shows its head word on `fifo_data_i` before the read, and the word is consumed at the clock edge where `fifo_re_o` is high.
- R3: Counting only words with `fifo_av_i` = 0, the first word of a macroblock appears on `quant_addr_o` and the second appears on `idct_addr_o`. Both are visible no later than the load pulse of that macroblock.
- R4: The third counted word is the control word. `acc_qp_o` takes bits 4..0, `acc_intra_o` takes bit 5 (1 = intra), and bit 6 has no effect, so `acc_chroma_o` stays 0. Both fields change on the same edge that starts a one-cycle `acc_load_qp_o` pulse, and they change at no other time.
- R5: For each data word, `acc_data_o` first carries bits 8..0 and then bits 24..16, each with `acc_wr_o` high. Bits 15..9 and 31..25 have no effect.
- R6: Writes are grouped in columns of eight. The first write of each column happens only in a cycle where `acc_col_ready_i` is 1. The other seven writes of the column do not wait for it.
- R7: After 192 counted data words, no FIFO word is read until every coefficient of the macroblock has been written. The block then parses a new header. A macroblock therefore produces exactly 384 writes.
- R8: A FIFO word with `fifo_av_i` = 1 is read and discarded in any phase. It counts neither as a header word nor as a data word.
- R9: With `SELF_RELEASE` = 1, `mb_ready_o` gives one one-cycle pulse per macroblock, after its last write. With `SELF_RELEASE` = 0, `mb_ready_o` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fifo_empty_i | input | 1 | Receive FIFO holds no word |
| fifo_av_i | input | 1 | Head word is a bus address word, to be dropped |
| fifo_data_i | input | 32 | Head word of the receive FIFO |
| fifo_re_o | output | 1 | Consume the head word at this edge |
| acc_data_o | output | 9 | Coefficient to the accelerator |
| acc_wr_o | output | 1 | Coefficient write strobe |
| acc_col_ready_i | input | 1 | Accelerator can take a new column |
| acc_qp_o | output | 5 | Quantizer parameter |
| acc_intra_o | output | 1 | 1 = intra macroblock |
| acc_chroma_o | output | 1 | Chroma flag, held at 0 |
| acc_load_qp_o | output | 1 | One-cycle pulse: QP and intra are new |
| quant_addr_o | output | 32 | Destination for quantized results |
| idct_addr_o | output | 32 | Destination for inverse-transform results |
| mb_ready_o | output | 1 | Ready for the next macroblock (release mode) |

## Verification
The assertions assume that the FIFO keeps its head word and its empty flag steady between clock edges. They also assume that the accelerator may lower column-ready at any time. They do not assume that the requester waits for results, so the stimulus sends the second macroblock's header right behind the first one's data. This makes the drain rule decide when the header is read. The bench's FIFO model drives all inputs half a cycle away from the sampling edge and offers only words it actually holds. It inserts address-valid words and empty gaps at header and data positions, and it toggles column-ready from a pseudo-random sequence, so that column starts stall at irregular points.

// File: rtl/mbu_pkg.sv
package mbu_pkg;
    // Parse phases of one macroblock; the order is the header order on the bus.
    typedef enum logic [2:0] {
        PH_QADDR = 3'd0,
        PH_IADDR = 3'd1,
        PH_CTRL  = 3'd2,
        PH_DATA  = 3'd3,
        PH_DRAIN = 3'd4
    } mbu_phase_e;

    localparam int unsigned MBU_BLOCKS_DEF  = 6;
    localparam int unsigned MBU_BLOCK_N_DEF = 64;
    localparam int unsigned MBU_COL_LEN_DEF = 8;
endpackage

// File: rtl/mbu_hdr_ctrl.sv
module mbu_hdr_ctrl
    import mbu_pkg::*;
#(
    parameter int unsigned BUS_W        = 32,
    parameter int unsigned QP_W         = 5,
    parameter int unsigned INTRA_BIT    = 5,
    parameter int unsigned WORDS_PER_MB = 192,
    parameter bit          SELF_RELEASE = 1'b1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             fifo_empty_i,
    input  logic             fifo_av_i,
    input  logic [BUS_W-1:0] fifo_data_i,
    input  logic             split_free_i,
    input  logic             split_busy_i,
    output logic             fifo_re_o,
    output logic             split_load_o,
    output logic [BUS_W-1:0] quant_addr_o,
    output logic [BUS_W-1:0] idct_addr_o,
    output logic [QP_W-1:0]  qp_o,
    output logic             intra_o,
    output logic             load_qp_o,
    output logic             mb_ready_o
);
    localparam int unsigned CNT_W = (WORDS_PER_MB > 1) ? $clog2(WORDS_PER_MB) : 1;
    localparam logic [CNT_W-1:0] LAST_WORD = CNT_W'(WORDS_PER_MB - 1);

    typedef struct packed {
        mbu_phase_e       phase;
        logic [CNT_W-1:0] cnt;
        logic [BUS_W-1:0] qaddr;
        logic [BUS_W-1:0] iaddr;
        logic [QP_W-1:0]  qp;
        logic             intra;
        logic             load_qp;
        logic             rel;
    } ctrl_t;

    ctrl_t st_d, st_q;
    logic  re_c, load_c, payload_c;

    always_comb begin
        st_d         = st_q;
        st_d.load_qp = 1'b0;
        st_d.rel     = 1'b0;
        re_c         = 1'b0;
        load_c       = 1'b0;
        unique case (st_q.phase)
            PH_QADDR, PH_IADDR, PH_CTRL: re_c = !fifo_empty_i;
            PH_DATA:                     re_c = !fifo_empty_i && split_free_i;
            default:                     re_c = 1'b0;
        endcase
        payload_c = re_c && !fifo_av_i;
        unique case (st_q.phase)
            PH_QADDR: if (payload_c) begin
                st_d.qaddr = fifo_data_i;
                st_d.phase = PH_IADDR;
            end
            PH_IADDR: if (payload_c) begin
                st_d.iaddr = fifo_data_i;
                st_d.phase = PH_CTRL;
            end
            PH_CTRL: if (payload_c) begin
                st_d.qp      = fifo_data_i[QP_W-1:0];
                st_d.intra   = fifo_data_i[INTRA_BIT];
                st_d.load_qp = 1'b1;
                st_d.cnt     = '0;
                st_d.phase   = PH_DATA;
            end
            PH_DATA: if (payload_c) begin
                load_c = 1'b1;
                if (st_q.cnt == LAST_WORD) begin
                    st_d.cnt   = '0;
                    st_d.phase = PH_DRAIN;
                end else begin
                    st_d.cnt = st_q.cnt + 1'b1;
                end
            end
            PH_DRAIN: if (!split_busy_i) begin
                st_d.phase = PH_QADDR;
                st_d.rel   = SELF_RELEASE;
            end
            default: st_d.phase = PH_QADDR;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{phase: PH_QADDR, default: '0};
        end else begin
            st_q <= st_d;
        end
    end

    assign fifo_re_o    = re_c;
    assign split_load_o = load_c;
    assign quant_addr_o = st_q.qaddr;
    assign idct_addr_o  = st_q.iaddr;
    assign qp_o         = st_q.qp;
    assign intra_o      = st_q.intra;
    assign load_qp_o    = st_q.load_qp;
    assign mb_ready_o   = st_q.rel;

    assert_read_nonempty_R2: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_re_o |-> !fifo_empty_i);
    assert_load_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
        load_qp_o |=> !load_qp_o);
    assert_qp_only_on_load_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable({qp_o, intra_o}) |-> load_qp_o);
    assert_drain_no_read_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.phase == PH_DRAIN) |-> !fifo_re_o);
    assert_release_after_drain_R9: assert property (@(posedge clk) disable iff (!rst_n)
        mb_ready_o |-> (SELF_RELEASE && $past(!split_busy_i)));
endmodule

// File: rtl/mbu_coef_split.sv
module mbu_coef_split #(
    parameter int unsigned COEF_W  = 9,
    parameter int unsigned COL_LEN = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_i,
    input  logic [COEF_W-1:0] lo_i,
    input  logic [COEF_W-1:0] hi_i,
    input  logic              col_ready_i,
    output logic              free_o,
    output logic              busy_o,
    output logic [COEF_W-1:0] coef_o,
    output logic              wr_o
);
    localparam int unsigned COL_W = (COL_LEN > 1) ? $clog2(COL_LEN) : 1;
    localparam logic [COL_W-1:0] COL_LAST = COL_W'(COL_LEN - 1);

    typedef struct packed {
        logic [COEF_W-1:0] lo;
        logic [COEF_W-1:0] hi;
        logic              hold;
        logic              upper;
        logic [COL_W-1:0]  col;
    } split_t;

    split_t sp_d, sp_q;
    logic   fire_c;

    always_comb begin
        sp_d   = sp_q;
        fire_c = sp_q.hold && ((sp_q.col != '0) || col_ready_i);
        if (fire_c) begin
            sp_d.col = (sp_q.col == COL_LAST) ? '0 : sp_q.col + 1'b1;
            if (sp_q.upper) begin
                sp_d.hold  = 1'b0;
                sp_d.upper = 1'b0;
            end else begin
                sp_d.upper = 1'b1;
            end
        end
        if (load_i) begin
            sp_d.lo    = lo_i;
            sp_d.hi    = hi_i;
            sp_d.hold  = 1'b1;
            sp_d.upper = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sp_q <= '0;
        end else begin
            sp_q <= sp_d;
        end
    end

    assign free_o = !sp_q.hold || (sp_q.upper && fire_c);
    assign busy_o = sp_q.hold;
    assign coef_o = sp_q.upper ? sp_q.hi : sp_q.lo;
    assign wr_o   = fire_c;

    assert_load_when_free_R5: assert property (@(posedge clk) disable iff (!rst_n)
        load_i |-> free_o);
    assert_low_then_high_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_o && !sp_q.upper) |=> (busy_o && sp_q.upper));
endmodule

// File: rtl/mbu_unpacker.sv
module mbu_unpacker
    import mbu_pkg::*;
#(
    parameter int unsigned BUS_W        = 32,
    parameter int unsigned COEF_W       = 9,
    parameter int unsigned QP_W         = 5,
    parameter int unsigned INTRA_BIT    = 5,
    parameter int unsigned BLOCKS       = MBU_BLOCKS_DEF,
    parameter int unsigned BLOCK_N      = MBU_BLOCK_N_DEF,
    parameter int unsigned COL_LEN      = MBU_COL_LEN_DEF,
    parameter bit          SELF_RELEASE = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fifo_empty_i,
    input  logic              fifo_av_i,
    input  logic [BUS_W-1:0]  fifo_data_i,
    output logic              fifo_re_o,
    output logic [COEF_W-1:0] acc_data_o,
    output logic              acc_wr_o,
    input  logic              acc_col_ready_i,
    output logic [QP_W-1:0]   acc_qp_o,
    output logic              acc_intra_o,
    output logic              acc_chroma_o,
    output logic              acc_load_qp_o,
    output logic [BUS_W-1:0]  quant_addr_o,
    output logic [BUS_W-1:0]  idct_addr_o,
    output logic              mb_ready_o
);
    localparam int unsigned HALF_W       = BUS_W / 2;
    localparam int unsigned WORDS_PER_MB = (BLOCKS * BLOCK_N) / 2;
    localparam int unsigned CHK_W        = (COL_LEN > 1) ? $clog2(COL_LEN) : 1;

    logic split_free, split_busy, split_load;

    mbu_hdr_ctrl #(
        .BUS_W       (BUS_W),
        .QP_W        (QP_W),
        .INTRA_BIT   (INTRA_BIT),
        .WORDS_PER_MB(WORDS_PER_MB),
        .SELF_RELEASE(SELF_RELEASE)
    ) u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .fifo_empty_i(fifo_empty_i),
        .fifo_av_i   (fifo_av_i),
        .fifo_data_i (fifo_data_i),
        .split_free_i(split_free),
        .split_busy_i(split_busy),
        .fifo_re_o   (fifo_re_o),
        .split_load_o(split_load),
        .quant_addr_o(quant_addr_o),
        .idct_addr_o (idct_addr_o),
        .qp_o        (acc_qp_o),
        .intra_o     (acc_intra_o),
        .load_qp_o   (acc_load_qp_o),
        .mb_ready_o  (mb_ready_o)
    );

    mbu_coef_split #(
        .COEF_W (COEF_W),
        .COL_LEN(COL_LEN)
    ) u_split (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_i     (split_load),
        .lo_i       (fifo_data_i[COEF_W-1:0]),
        .hi_i       (fifo_data_i[HALF_W+COEF_W-1:HALF_W]),
        .col_ready_i(acc_col_ready_i),
        .free_o     (split_free),
        .busy_o     (split_busy),
        .coef_o     (acc_data_o),
        .wr_o       (acc_wr_o)
    );

    // Chroma selection is not taken from the control word.
    assign acc_chroma_o = 1'b0;

    // Independent column tally for the pacing assertion.
    logic [CHK_W-1:0] chk_col_d, chk_col_q;
    always_comb begin
        chk_col_d = chk_col_q;
        if (acc_wr_o) begin
            chk_col_d = (chk_col_q == CHK_W'(COL_LEN - 1)) ? '0 : chk_col_q + 1'b1;
        end
    end
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chk_col_q <= '0;
        else        chk_col_q <= chk_col_d;
    end

    assert_column_start_ready_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_wr_o && chk_col_q == '0) |-> acc_col_ready_i);
    assert_no_write_while_reading_header_R7: assert property (@(posedge clk) disable iff (!rst_n)
        acc_load_qp_o |-> !$past(acc_wr_o));
endmodule

// File: tb/mbu_unpacker_bench.sv
module mbu_unpacker_bench;
    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic        rst_n = 1'b0;
    logic        fifo_empty = 1'b1, fifo_av = 1'b0, col_ready = 1'b0;
    logic [31:0] fifo_data = '0;
    logic        fifo_re, acc_wr, acc_intra, acc_chroma, acc_load_qp, mb_ready;
    logic [8:0]  acc_data;
    logic [4:0]  acc_qp;
    logic [31:0] quant_addr, idct_addr;

    mbu_unpacker u_mbu_unpacker (
        .clk(clk), .rst_n(rst_n),
        .fifo_empty_i(fifo_empty), .fifo_av_i(fifo_av), .fifo_data_i(fifo_data),
        .fifo_re_o(fifo_re), .acc_data_o(acc_data), .acc_wr_o(acc_wr),
        .acc_col_ready_i(col_ready), .acc_qp_o(acc_qp), .acc_intra_o(acc_intra),
        .acc_chroma_o(acc_chroma), .acc_load_qp_o(acc_load_qp),
        .quant_addr_o(quant_addr), .idct_addr_o(idct_addr), .mb_ready_o(mb_ready)
    );

    logic [32:0] fifo_q[$];   // {av, data}
    int          kind_q[$];   // 0 header, 1 data, 2 address-valid
    logic [8:0]  exp_coef[$];
    logic [31:0] exp_qa[$], exp_ia[$];
    logic [6:0]  exp_ctl[$];
    int n_cmp = 0, n_bad = 0;
    int wr_cnt = 0, load_cnt = 0, rel_cnt = 0, pend_coef = 0;
    logic pop_pend = 1'b0, prev_load = 1'b0;
    logic [7:0] lfsr = 8'hA5;
    logic [31:0] rng = 32'h1234_5678;
    bit   finished = 0;

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic push_word(input logic av, input logic [31:0] w, input int kind);
        fifo_q.push_back({av, w});
        kind_q.push_back(kind);
    endtask

    task automatic send_header(input logic [31:0] qa, input logic [31:0] ia, input logic [6:0] ctl);
        @(posedge clk); #2;
        push_word(1'b1, 32'hDEAD_0001, 2);
        push_word(1'b0, qa, 0);
        push_word(1'b1, 32'hDEAD_0002, 2);
        push_word(1'b0, ia, 0);
        push_word(1'b0, {25'h1ABCDE, ctl}, 0);
        exp_qa.push_back(qa);
        exp_ia.push_back(ia);
        exp_ctl.push_back(ctl);
    endtask

    task automatic send_data(input int first, input int count);
        @(posedge clk); #2;
        for (int i = first; i < first + count; i++) begin
            rng = rng ^ (rng << 13);
            rng = rng ^ (rng >> 17);
            rng = rng ^ (rng << 5);
            if (i % 50 == 7) push_word(1'b1, 32'hA0A0_0000 | i, 2);
            push_word(1'b0, rng, 1);
            exp_coef.push_back(rng[8:0]);
            exp_coef.push_back(rng[24:16]);
        end
    endtask

    // FIFO model and scoreboard monitor.
    initial begin
        forever begin
            @(negedge clk);
            if (pop_pend) begin
                if (kind_q[0] == 1) pend_coef += 2;
                void'(fifo_q.pop_front());
                void'(kind_q.pop_front());
            end
            lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
            col_ready = lfsr[0] | lfsr[2];
            fifo_empty = (fifo_q.size() == 0);
            fifo_data = fifo_empty ? 32'h0 : fifo_q[0][31:0];
            fifo_av = fifo_empty ? 1'b0 : fifo_q[0][32];
            #1;
            if (rst_n) begin
                if (fifo_re) check(!fifo_empty, "R2", "read while empty", {31'h0, fifo_empty}, 32'h0);
                if (fifo_re && !fifo_empty && kind_q[0] == 0)
                    check(pend_coef == 0, "R7", "header read before drain", pend_coef, 32'h0);
                if (acc_wr) begin
                    if (wr_cnt % 8 == 0)
                        check(col_ready, "R6", "column start without ready", {31'h0, col_ready}, 32'h1);
                    if (exp_coef.size() == 0) begin
                        check(1'b0, "R5", "unexpected write", {23'h0, acc_data}, 32'h0);
                    end else begin
                        check(acc_data == exp_coef[0], "R5", "coefficient", {23'h0, acc_data},
                              {23'h0, exp_coef[0]});
                        void'(exp_coef.pop_front());
                    end
                    wr_cnt++;
                    pend_coef--;
                end
                if (acc_load_qp) begin
                    check(!prev_load, "R4", "load pulse longer than one cycle", 32'h1, 32'h0);
                    if (exp_ctl.size() != 0) begin
                        check(acc_qp == exp_ctl[0][4:0], "R4", "qp", {27'h0, acc_qp}, {27'h0, exp_ctl[0][4:0]});
                        check(acc_intra == exp_ctl[0][5], "R4", "intra", {31'h0, acc_intra},
                              {31'h0, exp_ctl[0][5]});
                        check(acc_chroma == 1'b0, "R4", "chroma ignores bit 6", {31'h0, acc_chroma}, 32'h0);
                        check(quant_addr == exp_qa[0], "R3", "quant address (R8 skips av words)",
                              quant_addr, exp_qa[0]);
                        check(idct_addr == exp_ia[0], "R3", "idct address", idct_addr, exp_ia[0]);
                        void'(exp_ctl.pop_front());
                        void'(exp_qa.pop_front());
                        void'(exp_ia.pop_front());
                    end else begin
                        check(1'b0, "R4", "unexpected load pulse", 32'h1, 32'h0);
                    end
                    load_cnt++;
                end
                if (mb_ready) begin
                    check(pend_coef == 0 && wr_cnt % 384 == 0, "R9", "release before last write",
                          wr_cnt, 32'(384 * (rel_cnt + 1)));
                    rel_cnt++;
                end
                prev_load = acc_load_qp;
            end
            pop_pend = fifo_re && !fifo_empty;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_bad++;
            $display("FAIL R7 watchdog expired: writes %0d expected %0d", wr_cnt, 768);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        #2;
        check(!fifo_re && !acc_wr && !acc_load_qp && !mb_ready, "R1", "strobes in reset",
              {28'h0, fifo_re, acc_wr, acc_load_qp, mb_ready}, 32'h0);
        check(acc_qp == 0 && !acc_intra, "R1", "qp/intra in reset", {26'h0, acc_intra, acc_qp}, 32'h0);
        @(posedge clk); #3;
        rst_n = 1'b1;
        @(negedge clk); #2;
        check(!fifo_re && !acc_wr && !acc_load_qp && !mb_ready, "R1", "strobes after reset",
              {28'h0, fifo_re, acc_wr, acc_load_qp, mb_ready}, 32'h0);

        // Macroblock 1: intra, qp 0x13, chroma bit set (must be ignored).
        send_header(32'h1000_0040, 32'h2000_0080, 7'b111_0011);
        repeat (25) @(posedge clk);
        send_data(0, 100);
        repeat (40) @(posedge clk);
        send_data(100, 92);
        // Macroblock 2 header right behind: must wait for the drain (R7).
        send_header(32'h1000_0100, 32'hFFFF_FFF0, 7'b001_1111);
        send_data(0, 192);

        for (int t = 0; t < 20000 && !(wr_cnt >= 768 && rel_cnt >= 2); t++) @(posedge clk);
        repeat (20) @(posedge clk);
        @(negedge clk); #3;
        check(wr_cnt == 768, "R7", "total writes", wr_cnt, 32'd768);
        check(load_cnt == 2, "R4", "load pulses", load_cnt, 32'd2);
        check(rel_cnt == 2, "R9", "release pulses", rel_cnt, 32'd2);
        check(exp_coef.size() == 0, "R5", "coefficients left", exp_coef.size(), 32'h0);
        check(fifo_q.size() == 0, "R8", "words left in FIFO", fifo_q.size(), 32'h0);
        check(acc_qp == 5'h1F && !acc_intra, "R4", "final qp/intra", {26'h0, acc_intra, acc_qp}, 32'h1F);
        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule